// File: doc/BRIEF.md
# Two-Wire Slave for a 16-Bit Quasi-Bidirectional Port

This block is the serial-bus slave engine of a 16-bit general-purpose port expander. It watches the open-drain clock and data lines of an I2C bus through a faster system clock. It recognises start and stop conditions and answers only to its own 7-bit address. The top four address bits are fixed at 0100, and three strap inputs set the low three bits. The only thing it drives on the bus is a pull-down request for the data line.

A write transfer fills the 16-bit output latch in byte pairs. The first data byte of each pair is held internally. The second byte completes the word, and both bytes reach the latch together during that byte's acknowledge clock. A read transfer returns the live pin values, low byte first and then the high byte, for as long as the master keeps acknowledging.

When a word is committed, every bit written as 1 gets a short strong-pullup pulse that ends at the next falling edge of the clock. Two one-cycle strobes mark the data-byte acknowledges of reads and writes. The interrupt logic beside the block uses them.

Top module: `i2c_port_expander`

## Requirements
- R1: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high. Bits clocked while no transfer has been opened by a start are ignored and draw no acknowledge.
- R2: The address byte is sent MSB first as 0,1,0,0,strap[2],strap[1],strap[0], then a direction bit (1 = read). A match is acknowledged. A mismatch draws no acknowledge, and the data that follows leaves the latch unchanged.
- R3: The general call address (byte 0x00) is never acknowledged.
- R4: In a write, data bytes go alternately to latch bits 7..0 and then 15..8. Each further pair in the same transfer overwrites the previous word.
- R5: The latch does not change after the first byte of a pair. It takes the new 16-bit word only in the acknowledge clock of the second byte.
- R6: In a read, each byte is the live pin value, MSB first, alternating pins 7..0 and pins 15..8. Each byte is sampled at the falling clock edge that ends the acknowledge before it.
- R7: On a commit, the strong-pullup enable rises for exactly the bits written 1. It clears at the next falling clock edge and is never set for a bit whose latch value is 0.
- R8: After reset the latch is all ones, the pullup enable is all zeros and the data line is released.
- R9: A start or stop in the middle of a transfer ends it, and any first byte of a pair not yet completed is discarded.
- R10: wr_ack_strobe pulses for one cycle at each acknowledged write data byte. rd_ack_strobe pulses for one cycle at the acknowledge clock of each byte read. The two never coincide.
- R11: The slave holds the data line low (sda_pull_o = 1) for the whole high phase of an acknowledge clock. It releases the line after a read byte, whether the master then acknowledges or not, and it changes its pull only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| strap_i | input | 3 | Address strap value, low three address bits |
| pin_i | input | 16 | Present level of the 16 port pins |
| latch_o | output | 16 | Port output latch; 0 drives low, 1 is weak high |
| boost_o | output | 16 | Per-pin strong-pullup enable |
| rd_ack_strobe | output | 1 | One-cycle pulse at a read data-byte acknowledge |
| wr_ack_strobe | output | 1 | One-cycle pulse at a write data-byte acknowledge |

## Verification
The assertions assume a bus clock whose high and low phases each last several system clocks. With that margin the two-stage line synchronizer settles and the slave's pull changes well inside the low phase. They also assume the master moves the data line only while the clock is low, except at its own start and stop conditions. The bench holds each bus phase for ten system clocks. It changes data only inside the low phase, keeps the straps fixed for the length of each transfer, and changes pin values only after the byte that reads them has been loaded.

// File: rtl/pex_pkg.sv
package pex_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_WR_BYTE  = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_RD_BYTE  = 3'd5,
        ST_RD_ACK   = 3'd6,
        ST_IGNORE   = 3'd7
    } pex_state_e;

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;
    localparam int LN_CNT = 2;

endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            typedef struct packed {
                logic [STAGES-1:0] chain;
                logic              prev;
            } sync_t;

            sync_t s_d, s_q;

            always_comb begin
                s_d       = s_q;
                s_d.chain = {s_q.chain[STAGES-2:0], raw_i[g]};
                s_d.prev  = s_q.chain[STAGES-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= s_d;
            end

            assign lvl_o[g]  = s_q.chain[STAGES-1];
            assign rise_o[g] = s_q.chain[STAGES-1] & ~s_q.prev;
            assign fall_o[g] = ~s_q.chain[STAGES-1] & s_q.prev;
        end
    endgenerate

endmodule

// File: rtl/pex_engine.sv
module pex_engine
    import pex_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int STRAP_W = 3,
    parameter logic [BYTE_W-2-STRAP_W:0] DEV_PREFIX = 4'b0100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_lvl,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  sda_lvl,
    input  logic                  sda_rise,
    input  logic                  sda_fall,
    input  logic [STRAP_W-1:0]    strap_i,
    input  logic [2*BYTE_W-1:0]   pin_i,
    output logic                  sda_pull_o,
    output logic                  rd_stb_o,
    output logic                  wr_stb_o,
    output logic                  commit_o,
    output logic [2*BYTE_W-1:0]   word_o
);

    localparam int PORT_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        pex_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shreg;
        logic               rw;
        logic               next_hi;
        logic [BYTE_W-1:0]  low_hold;
        logic               pull;
        logic               mack;
        logic               wr_stb;
        logic               rd_stb;
        logic               commit;
        logic [PORT_W-1:0]  word;
    } eng_t;

    eng_t r_d, r_q;

    logic              bus_start;
    logic              bus_stop;
    logic              addr_hit;
    logic              byte_done;
    logic [BYTE_W-1:0] pick_byte;

    assign bus_start = sda_fall & scl_lvl;
    assign bus_stop  = sda_rise & scl_lvl;
    assign addr_hit  = (r_q.shreg[BYTE_W-1:1] == {DEV_PREFIX, strap_i});
    assign byte_done = scl_fall & (r_q.cnt == LAST_BIT);
    assign pick_byte = r_q.next_hi ? pin_i[PORT_W-1:BYTE_W] : pin_i[BYTE_W-1:0];

    always_comb begin
        r_d        = r_q;
        r_d.wr_stb = 1'b0;
        r_d.rd_stb = 1'b0;
        r_d.commit = 1'b0;

        if (bus_start) begin
            r_d.state   = ST_ADDR;
            r_d.cnt     = '0;
            r_d.pull    = 1'b0;
            r_d.next_hi = 1'b0;
        end else if (bus_stop) begin
            r_d.state   = ST_IDLE;
            r_d.pull    = 1'b0;
            r_d.next_hi = 1'b0;
        end else begin
            case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_lvl};
                        r_d.cnt   = r_q.cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        if (addr_hit) begin
                            r_d.pull  = 1'b1;
                            r_d.rw    = r_q.shreg[0];
                            r_d.state = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.shreg   = pick_byte;
                            r_d.pull    = ~pick_byte[BYTE_W-1];
                            r_d.next_hi = ~r_q.next_hi;
                            r_d.state   = ST_RD_BYTE;
                        end else begin
                            r_d.pull  = 1'b0;
                            r_d.state = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_lvl};
                        r_d.cnt   = r_q.cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        r_d.pull  = 1'b1;
                        r_d.state = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_rise) begin
                        r_d.wr_stb = 1'b1;
                        if (r_q.next_hi) begin
                            r_d.commit  = 1'b1;
                            r_d.word    = {r_q.shreg, r_q.low_hold};
                            r_d.next_hi = 1'b0;
                        end else begin
                            r_d.low_hold = r_q.shreg;
                            r_d.next_hi  = 1'b1;
                        end
                    end else if (scl_fall) begin
                        r_d.pull  = 1'b0;
                        r_d.cnt   = '0;
                        r_d.state = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        r_d.pull  = 1'b0;
                        r_d.state = ST_RD_ACK;
                    end else if (scl_fall) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], 1'b0};
                        r_d.pull  = ~r_q.shreg[BYTE_W-2];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        r_d.mack   = ~sda_lvl;
                        r_d.rd_stb = 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.shreg   = pick_byte;
                            r_d.pull    = ~pick_byte[BYTE_W-1];
                            r_d.next_hi = ~r_q.next_hi;
                            r_d.cnt     = '0;
                            r_d.state   = ST_RD_BYTE;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_pull_o = r_q.pull;
    assign rd_stb_o   = r_q.rd_stb;
    assign wr_stb_o   = r_q.wr_stb;
    assign commit_o   = r_q.commit;
    assign word_o     = r_q.word;

endmodule

// File: rtl/pex_port.sv
module pex_port #(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [PORT_W-1:0] word_i,
    input  logic              scl_fall_i,
    output logic [PORT_W-1:0] latch_o,
    output logic [PORT_W-1:0] boost_o
);

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] boost;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (scl_fall_i) p_d.boost = '0;
        if (commit_i) begin
            p_d.latch = word_i;
            p_d.boost = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{latch: '1, boost: '0};
        else        p_q <= p_d;
    end

    assign latch_o = p_q.latch;
    assign boost_o = p_q.boost;

endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
    import pex_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int STRAP_W = 3,
    parameter int STAGES  = 2,
    parameter logic [BYTE_W-2-STRAP_W:0] DEV_PREFIX = 4'b0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_pull_o,
    input  logic [STRAP_W-1:0]   strap_i,
    input  logic [2*BYTE_W-1:0]  pin_i,
    output logic [2*BYTE_W-1:0]  latch_o,
    output logic [2*BYTE_W-1:0]  boost_o,
    output logic                 rd_ack_strobe,
    output logic                 wr_ack_strobe
);

    localparam int PORT_W = 2 * BYTE_W;

    logic [LN_CNT-1:0] ln_lvl, ln_rise, ln_fall;
    logic              commit;
    logic [PORT_W-1:0] word;

    pex_sync #(.LINES(LN_CNT), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (ln_lvl),
        .rise_o (ln_rise),
        .fall_o (ln_fall)
    );

    pex_engine #(.BYTE_W(BYTE_W), .STRAP_W(STRAP_W), .DEV_PREFIX(DEV_PREFIX)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl    (ln_lvl[LN_SCL]),
        .scl_rise   (ln_rise[LN_SCL]),
        .scl_fall   (ln_fall[LN_SCL]),
        .sda_lvl    (ln_lvl[LN_SDA]),
        .sda_rise   (ln_rise[LN_SDA]),
        .sda_fall   (ln_fall[LN_SDA]),
        .strap_i    (strap_i),
        .pin_i      (pin_i),
        .sda_pull_o (sda_pull_o),
        .rd_stb_o   (rd_ack_strobe),
        .wr_stb_o   (wr_ack_strobe),
        .commit_o   (commit),
        .word_o     (word)
    );

    pex_port #(.PORT_W(PORT_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .word_i     (word),
        .scl_fall_i (ln_fall[LN_SCL]),
        .latch_o    (latch_o),
        .boost_o    (boost_o)
    );

endmodule

// File: rtl/pex_checks.sv
module pex_checks #(
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic [PORT_W-1:0] latch_o,
    input logic [PORT_W-1:0] boost_o,
    input logic              rd_ack_strobe,
    input logic              wr_ack_strobe
);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack_strobe && wr_ack_strobe));

    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack_strobe |=> !wr_ack_strobe);

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_strobe |=> !rd_ack_strobe);

    p_latch_at_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o != $past(latch_o)) |-> $past(wr_ack_strobe));

    p_boost_high_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_o & ~latch_o) == '0);

    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);

endmodule

bind i2c_port_expander pex_checks #(.PORT_W(2 * BYTE_W)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_pull_o    (sda_pull_o),
    .latch_o       (latch_o),
    .boost_o       (boost_o),
    .rd_ack_strobe (rd_ack_strobe),
    .wr_ack_strobe (wr_ack_strobe)
);

// File: tb/tb_i2c_port_expander.sv
module tb_i2c_port_expander;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 10;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic [15:0] pins  = 16'h0000;
    logic        sda_pull;
    logic        rd_stb, wr_stb;
    logic [15:0] latch, boost;
    logic        sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_port_expander dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_pull_o    (sda_pull),
        .strap_i       (strap),
        .pin_i         (pins),
        .latch_o       (latch),
        .boost_o       (boost),
        .rd_ack_strobe (rd_stb),
        .wr_ack_strobe (wr_stb)
    );

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    int mon_bad = 0;

    always @(posedge clk) begin
        if (rd_stb) n_rd++;
        if (wr_stb) n_wr++;
        if (rst_n && ((boost & ~latch) != 16'h0)) mon_bad++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked, output logic [15:0] boost_seen);
        logic a0, a1;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(2);
        a0 = sda_bus; wait_clk(5);
        a1 = sda_bus;
        boost_seen = boost; wait_clk(3);
        scl_m = 1'b0; wait_clk(5);
        acked = !a0 && !a1;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(H);
            scl_m = 1'b1; wait_clk(7);
            v[i] = sda_bus; wait_clk(3);
            scl_m = 1'b0;
        end
        send_bit(!mack);
        wait_clk(5);
    endtask

    initial begin
        logic        ack;
        logic [15:0] bs;
        logic [7:0]  rb;
        int          base_rd, base_wr;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R8: reset state
        chk("R8 latch", latch, 16'hFFFF);
        chk("R8 boost", boost, 16'h0000);
        chk("R8 sda", sda_pull, 1'b0);

        // R2/R4/R5/R7/R10: write two pairs
        base_rd = n_rd; base_wr = n_wr;
        bus_start();
        send_byte(8'h4A, ack, bs); chk("R2 addr ack", ack, 1'b1);
        send_byte(8'h5A, ack, bs); chk("R11 data ack", ack, 1'b1);
        chk("R5 latch after first byte", latch, 16'hFFFF);
        send_byte(8'hC3, ack, bs);
        chk("R7 boost in ack", bs, 16'hC35A);
        chk("R4 first pair", latch, 16'hC35A);
        chk("R7 boost after fall", boost, 16'h0000);
        send_byte(8'h0F, ack, bs);
        chk("R5 latch holds mid pair", latch, 16'hC35A);
        send_byte(8'hF0, ack, bs);
        chk("R4 overwrite pair", latch, 16'hF00F);
        bus_stop();
        chk("R10 write strobes", n_wr - base_wr, 4);
        chk("R10 no read strobe on write", n_rd - base_rd, 0);

        // R2: address mismatch
        bus_start();
        send_byte(8'h40, ack, bs); chk("R2 mismatch nack", ack, 1'b0);
        send_byte(8'h00, ack, bs);
        send_byte(8'h00, ack, bs);
        bus_stop();
        chk("R2 mismatch leaves latch", latch, 16'hF00F);

        // R3: general call
        bus_start();
        send_byte(8'h00, ack, bs); chk("R3 general call nack", ack, 1'b0);
        bus_stop();

        // R1: no start, bits ignored
        scl_m = 1'b0; wait_clk(H);
        send_byte(8'h4A, ack, bs); chk("R1 no start nack", ack, 1'b0);
        bus_stop();

        // R9: repeated start discards half pair
        bus_start();
        send_byte(8'h4A, ack, bs);
        send_byte(8'h11, ack, bs);
        bus_start();
        send_byte(8'h4A, ack, bs); chk("R1 repeated start ack", ack, 1'b1);
        send_byte(8'h22, ack, bs);
        send_byte(8'h33, ack, bs);
        chk("R9 repeated start pair", latch, 16'h3322);
        send_byte(8'h66, ack, bs);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        chk("R9 stop mid byte", latch, 16'h3322);

        // R6/R10/R11: read
        pins = 16'hA55A;
        base_rd = n_rd; base_wr = n_wr;
        bus_start();
        send_byte(8'h4B, ack, bs); chk("R2 read addr ack", ack, 1'b1);
        recv_byte(1'b1, rb); chk("R6 low byte", rb, 8'h5A);
        pins = 16'h1234;
        recv_byte(1'b1, rb); chk("R6 high byte", rb, 8'hA5);
        recv_byte(1'b0, rb); chk("R6 live low byte", rb, 8'h34);
        wait_clk(H);
        chk("R11 released after nack", sda_pull, 1'b0);
        bus_stop();
        chk("R10 read strobes", n_rd - base_rd, 3);
        chk("R10 no write strobe on read", n_wr - base_wr, 0);
        chk("R6 read leaves latch", latch, 16'h3322);

        // R2: other strap value
        strap = 3'b010;
        wait_clk(H);
        bus_start();
        send_byte(8'h4A, ack, bs); chk("R2 old address nack", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h44, ack, bs); chk("R2 new strap ack", ack, 1'b1);
        send_byte(8'h01, ack, bs);
        send_byte(8'h80, ack, bs);
        chk("R7 boost single bits", bs, 16'h8001);
        bus_stop();
        chk("R4 strap write", latch, 16'h8001);

        chk("R7 boost never on low latch bit", mon_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule